// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Band

The block is a reload timer that drives a pulse-width-modulated output and, when asked, a complementary output. A free-running up-counter runs from 1 to a programmed top value and then starts again at 1. On each wrap the block raises a one-clock reload pulse. A programmable match value sets the point in the period where the primary output turns on. The wrap turns it off again.

A single polarity bit sets the level each output takes while the timer is stopped. The same bit sets the sense of the match and reload transitions. In dual mode the complementary output follows the inverse of the primary. An 8-bit dead-band count delays each output's move to its on state, so that the two outputs are never on together. The surrounding logic supplies all configuration as plain inputs. Prescaling, bus access and interrupt handling sit outside this block.

Top module: `cpwm_gen`

## Requirements
- R1: Reset state and disabled state. Whenever `en` was low at the previous clock edge, `pwm_out` equals `pol` and `pwm_out_n` equals the inverse of `pol`. `reload_pulse` is low while `en` is low.
- R2: The counter holds 1 while disabled. While enabled it advances by one per clock. When it reaches `reload_val` or more, `reload_pulse` is high for that cycle (`reload_pulse = en && count >= reload_val`) and the next count is 1. With `reload_val` > 1 the pulse recurs every `reload_val` clocks and never lasts two cycles in a row.
- R3: With `pol` = 0, the primary is on when `pwm_out` is high. The internal on-request is set at the clock edge where the count equals a valid match value. The output goes high `db_count`+1 edges after that edge. The internal on-request is cleared at the edge where the count reaches the reload value, and the output goes low one edge later.
- R4: With `pol` = 1, every level of `pwm_out` is the inverse of the R3 level. It is high when disabled, low after a match, and high after a reload.
- R5: In dual mode (`dual_en` = 1), the complementary output is on when `pwm_out_n` is at the inverse of `pol` (high for `pol` = 0). It turns off one edge after the match edge. It turns back on `db_count`+1 edges after the reload edge.
- R6: Dead band. An output whose request has just risen stays off for `db_count` extra cycles. An output request shorter than that never shows. In dual mode the two outputs are never on in the same cycle.
- R7: When `db_count` is 0 in dual mode, `pwm_out_n` is the exact inverse of `pwm_out` in every cycle.
- R8: When `dual_en` was low at the previous edge, `pwm_out_n` stays at the inverse of `pol`.
- R9: A match value of 0, or one greater than or equal to the reload value, never turns the primary on. `pwm_out` then stays at `pol` with no glitch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Timer run enable |
| reload_val | input | CNT_W | Top count of the period |
| match_val | input | CNT_W | Count at which the primary output turns on |
| pol | input | 1 | Polarity: idle level of `pwm_out`, inverse idle of `pwm_out_n` |
| dual_en | input | 1 | 1 enables the complementary output |
| db_count | input | DB_W | Dead-band delay in clock cycles |
| pwm_out | output | 1 | Primary PWM output |
| pwm_out_n | output | 1 | Complementary PWM output |
| reload_pulse | output | 1 | One-cycle pulse when the count wraps |

## Verification
The bench builds the block with an 8-bit counter and a 4-bit dead-band count. These values bring a full-range period of 255 clocks and the largest dead band of 15 cycles within reach. Together they cover counter saturation at the top value and dead bands that are longer than the on-time. Random configurations mix both polarities, both output modes, match values outside the valid range and mid-run stops. Directed runs add the zero dead-band inverse case and reload values of 0 and 1.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int unsigned CPWM_CNT_W_DEF = 16;
  localparam int unsigned CPWM_DB_W_DEF  = 8;

  // Output lane indices for the dead-band generate loop
  localparam int unsigned LANE_PRIM = 0;
  localparam int unsigned LANE_COMP = 1;
  localparam int unsigned LANES     = 2;

  // Map an "on" state to a pin level under a given polarity
  function automatic logic level_for(input logic pol, input logic on);
    return pol ^ on;
  endfunction
endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] match_val,
  output logic             reload_hit,
  output logic             match_hit,
  output logic             raw_on
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;

  function automatic logic at_top(input logic [CNT_W-1:0] c,
                                  input logic [CNT_W-1:0] top);
    return c >= top;
  endfunction

  function automatic logic match_valid(input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] m,
                                       input logic [CNT_W-1:0] top);
    return (m != '0) && (m <= top) && (c == m);
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] top);
    return at_top(c, top) ? ONE : c + ONE;
  endfunction

  assign reload_hit = en && at_top(count_q, reload_val);
  assign match_hit  = en && match_valid(count_q, match_val, reload_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= ONE;
      raw_on  <= 1'b0;
    end else if (!en) begin
      count_q <= ONE;
      raw_on  <= 1'b0;
    end else begin
      count_q <= next_count(count_q, reload_val);
      if (reload_hit)     raw_on <= 1'b0;   // reload wins over a coincident match
      else if (match_hit) raw_on <= 1'b1;
    end
  end
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int unsigned DB_W   = 8,
  parameter logic        RST_ON = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_i,
  input  logic            hold_val_i,
  input  logic            req_i,
  input  logic [DB_W-1:0] db_i,
  output logic            on_o
);
  logic [DB_W-1:0] elapsed_q;

  function automatic logic delay_done(input logic [DB_W-1:0] e,
                                      input logic [DB_W-1:0] d);
    return e >= d;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_o      <= RST_ON;
      elapsed_q <= '0;
    end else if (hold_i) begin
      on_o      <= hold_val_i;
      elapsed_q <= '0;
    end else if (!req_i) begin
      on_o      <= 1'b0;
      elapsed_q <= '0;
    end else if (delay_done(elapsed_q, db_i)) begin
      on_o      <= 1'b1;
    end else begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end
endmodule

// File: rtl/cpwm_gen.sv
module cpwm_gen
  import cpwm_pkg::*;
#(
  parameter int unsigned CNT_W = CPWM_CNT_W_DEF,
  parameter int unsigned DB_W  = CPWM_DB_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] match_val,
  input  logic             pol,
  input  logic             dual_en,
  input  logic [DB_W-1:0]  db_count,
  output logic             pwm_out,
  output logic             pwm_out_n,
  output logic             reload_pulse
);
  logic reload_hit, match_hit, raw_on;
  logic [LANES-1:0] lane_req, lane_hold, lane_hold_val, lane_on;
  logic prim_on, comp_on;

  cpwm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .reload_val (reload_val),
    .match_val  (match_val),
    .reload_hit (reload_hit),
    .match_hit  (match_hit),
    .raw_on     (raw_on)
  );

  // Primary lane follows the raw request; complement lane its inverse.
  assign lane_req[LANE_PRIM]      = raw_on;
  assign lane_hold[LANE_PRIM]     = !en;
  assign lane_hold_val[LANE_PRIM] = 1'b0;
  assign lane_req[LANE_COMP]      = !raw_on;
  assign lane_hold[LANE_COMP]     = !(en && dual_en);
  assign lane_hold_val[LANE_COMP] = 1'b1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cpwm_deadband #(
      .DB_W   (DB_W),
      .RST_ON (g == LANE_COMP)
    ) u_db (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold_i     (lane_hold[g]),
      .hold_val_i (lane_hold_val[g]),
      .req_i      (lane_req[g]),
      .db_i       (db_count),
      .on_o       (lane_on[g])
    );
  end

  assign prim_on      = lane_on[LANE_PRIM];
  assign comp_on      = lane_on[LANE_COMP];
  assign pwm_out      = level_for(pol, prim_on);
  assign pwm_out_n    = level_for(pol, comp_on);
  assign reload_pulse = reload_hit;
endmodule

// File: rtl/cpwm_gen_chk.sv
module cpwm_gen_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DB_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pol,
  input logic             dual_en,
  input logic [CNT_W-1:0] reload_val,
  input logic [DB_W-1:0]  db_count,
  input logic             pwm_out,
  input logic             pwm_out_n,
  input logic             reload_pulse,
  input logic             raw_on,
  input logic             match_hit,
  input logic             prim_on
);
  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (pwm_out == pol && pwm_out_n == !pol));

  assert_reload_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_pulse && reload_val > CNT_W'(1)) |=> !(reload_pulse && $stable(reload_val)));

  assert_match_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_on) |-> $past(match_hit));

  assert_db_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prim_on) |-> $past(raw_on));

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_en && $past(dual_en)) |-> !((pwm_out ^ pol) && (pwm_out_n ^ pol)));

  assert_db0_inverse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dual_en) && $past(db_count) == '0) |-> (pwm_out_n == !pwm_out));

  assert_single_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dual_en) |-> (pwm_out_n == !pol));
endmodule

bind cpwm_gen cpwm_gen_chk #(.CNT_W(CNT_W), .DB_W(DB_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .pol          (pol),
  .dual_en      (dual_en),
  .reload_val   (reload_val),
  .db_count     (db_count),
  .pwm_out      (pwm_out),
  .pwm_out_n    (pwm_out_n),
  .reload_pulse (reload_pulse),
  .raw_on       (raw_on),
  .match_hit    (match_hit),
  .prim_on      (prim_on)
);

// File: tb/cpwm_gen_tb.sv
`timescale 1ns/1ps
module cpwm_gen_tb;
  localparam int unsigned CW = 8;
  localparam int unsigned DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [CW-1:0] reload_val = CW'(10);
  logic [CW-1:0] match_val = CW'(4);
  logic pol = 1'b0;
  logic dual_en = 1'b0;
  logic [DW-1:0] db_count = '0;
  logic pwm_out, pwm_out_n, reload_pulse;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  cpwm_gen #(.CNT_W(CW), .DB_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .reload_val(reload_val),
    .match_val(match_val), .pol(pol), .dual_en(dual_en), .db_count(db_count),
    .pwm_out(pwm_out), .pwm_out_n(pwm_out_n), .reload_pulse(reload_pulse)
  );

  // Reference model, written from the requirements
  int  m_cnt;
  bit  m_req, m_p, m_c;
  int  m_pe, m_ce;

  function automatic bit wraps(int c, int top);
    return c >= top;
  endfunction

  function automatic bit sets_on(int c, int m, int top);
    return m != 0 && m < top && c == m;  // m == top: wrap takes priority
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 1; m_req = 0; m_p = 0; m_c = 1; m_pe = 0; m_ce = 0;
    end else begin
      bit old_req;
      old_req = m_req;
      // primary lane
      if (!en || !old_req) begin m_p = 0; m_pe = 0; end
      else if (m_pe >= int'(db_count)) m_p = 1;
      else m_pe++;
      // complementary lane
      if (!(en && dual_en)) begin m_c = 1; m_ce = 0; end
      else if (old_req) begin m_c = 0; m_ce = 0; end
      else if (m_ce >= int'(db_count)) m_c = 1;
      else m_ce++;
      // request and count
      if (!en) begin m_req = 0; m_cnt = 1; end
      else begin
        if (wraps(m_cnt, int'(reload_val))) m_req = 0;
        else if (sets_on(m_cnt, int'(match_val), int'(reload_val))) m_req = 1;
        m_cnt = wraps(m_cnt, int'(reload_val)) ? 1 : m_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: sample at the falling edge, compare against the model
  task automatic step();
    logic ep, ec, er;
    @(negedge clk);
    ep = pol ^ m_p;
    ec = pol ^ m_c;
    er = en && wraps(m_cnt, int'(reload_val));
    check(pwm_out === ep, !en ? "R1" : (pol ? "R4" : "R3"), pwm_out, ep);
    check(pwm_out_n === ec, dual_en ? "R5" : "R8", pwm_out_n, ec);
    check(reload_pulse === er, "R2", reload_pulse, er);
    if (dual_en)
      check(!((pwm_out ^ pol) && (pwm_out_n ^ pol)), "R6 overlap",
            pwm_out_n, ~pwm_out);
    if (dual_en && db_count == '0)
      check(pwm_out_n === ~pwm_out, "R7", pwm_out_n, ~pwm_out);
    if (!dual_en)
      check(pwm_out_n === ~pol, "R8", pwm_out_n, ~pol);
    if (match_val == '0 || match_val >= reload_val)
      check(pwm_out === pol, "R9", pwm_out, pol);
  endtask

  task automatic run_cfg(input int rl, input int mt, input int db,
                         input bit p, input bit d, input int cycles);
    @(negedge clk);
    en = 1'b0;
    reload_val = CW'(rl); match_val = CW'(mt); db_count = DW'(db);
    pol = p; dual_en = d;
    step();
    check(pwm_out === p && pwm_out_n === ~p, "R1 idle", pwm_out, p);
    en = 1'b1;
    for (int i = 0; i < cycles; i++) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pwm_out === 1'b0 && pwm_out_n === 1'b1 && reload_pulse === 1'b0,
          "R1 reset", pwm_out, 1'b0);
    rst_n = 1'b1;
    step();

    // Directed corners
    run_cfg(10, 4, 0, 0, 1, 40);    // R7 zero dead band, dual
    run_cfg(10, 4, 3, 1, 1, 40);    // R4 R6 inverted with dead band
    run_cfg(12, 5, 2, 0, 0, 40);    // R8 single mode
    run_cfg(10, 0, 1, 0, 1, 30);    // R9 match zero
    run_cfg(10, 15, 1, 1, 1, 30);   // R9 match above reload
    run_cfg(10, 10, 0, 0, 1, 30);   // R9 match equal reload
    run_cfg(10, 8, 15, 0, 1, 40);   // R6 dead band longer than on-time
    run_cfg(1, 1, 0, 0, 1, 10);     // R2 reload of one
    run_cfg(0, 0, 0, 1, 1, 10);     // R2 reload of zero
    run_cfg(255, 100, 15, 0, 1, 520); // R2 full-range period

    // Directed R2 period measurement
    begin
      int first, second, t;
      first = -1; second = -1; t = 0;
      @(negedge clk); en = 1'b0; reload_val = CW'(7); match_val = CW'(3);
      step(); en = 1'b1;
      while (second < 0 && t < 50) begin
        step(); t++;
        if (reload_pulse) begin
          if (first < 0) first = t; else second = t;
        end
      end
      check(second - first == 7, "R2 period", 1'b0, 1'b1);
    end

    // Constrained random
    void'($urandom(32'd2024));
    for (int k = 0; k < 40; k++) begin
      int rl, mt, db, cyc;
      rl  = 2 + int'($urandom % 30);
      mt  = int'($urandom % (rl + 4));
      db  = int'($urandom % 6);
      cyc = 3 * rl + 10;
      run_cfg(rl, mt, db, 1'($urandom), 1'($urandom), cyc);
      if ($urandom % 3 == 0) begin   // mid-run stop and restart, R1
        en = 1'b0;
        for (int j = 0; j < 3; j++) step();
        en = 1'b1;
        for (int j = 0; j < rl + 5; j++) step();
      end
    end

    en = 1'b0;
    step();
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule